// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block holds the program counter of a 16-bit, byte-addressed processor whose instructions are two bytes long. It chooses the address of the next instruction each clock. An instruction decoder presents one set of control flags per cycle, along with the source register value, two offsets that are already sign-extended, and the saved exception return address. From these the block picks one of five targets: the sequential address, a PC-relative target, a register-relative target, a taken conditional branch, or a return from exception.

It also produces three more outputs. The first is the return-link value that a call writes into the link register. The second is a redirect flag, which the pipeline uses to flush the instructions it fetched down the sequential path. The third is a halted status. A halt instruction steps the PC once past itself and then freezes it. Once that happens, every later control flag is ignored until reset.

Top module: `nextPcUnit`

## Requirements
- R1: While `rstN` is low and after it rises, `pcQ` is 0 and `halted` is 0 until the first clock edge with `rstN` high.
- R2: With no flag set and not halted, `nextPc` is `pcQ + 2` (modulo 2^16), `redirect` is 0, and `pcQ` takes `nextPc` at the next clock edge.
- R3: A relative jump (`jumpRel`=1) gives `nextPc = pcQ + 2 + offLong`, with `redirect` = 1.
- R4: A register jump (`jumpReg`=1) gives `nextPc = rsVal + offShort`, with `redirect` = 1.
- R5: A conditional branch (`branchEn`=1) tests `rsVal` according to `branchCond`. 2'b00 is taken when the value is zero, 2'b01 when it is nonzero, 2'b10 when bit 15 is 1, and 2'b11 when bit 15 is 0. When taken, `nextPc = pcQ + 2 + offShort` and `redirect` = 1. When not taken, `nextPc = pcQ + 2` and `redirect` = 0.
- R6: An exception return (`rtiEn`=1) gives `nextPc = epcVal`, with `redirect` = 1.
- R7: A halt (`haltEn`=1) while not halted gives `nextPc = pcQ + 2` and `redirect` = 0. `halted` reads 1 from the next clock edge onward.
- R8: While `halted` is 1, `nextPc` equals `pcQ`, `pcQ` does not change, `redirect` is 0, and every control flag is ignored until reset.
- R9: When several flags are set together, the order of precedence is halt, then exception return, then register jump, then relative jump, then branch.
- R10: `linkVal` is always `pcQ + 2` (modulo 2^16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| jumpRel | input | 1 | PC-relative jump, with or without link |
| jumpReg | input | 1 | Register-relative jump, with or without link |
| branchEn | input | 1 | Conditional branch on the register value |
| branchCond | input | 2 | Branch test selector (see R5) |
| rtiEn | input | 1 | Return from exception |
| haltEn | input | 1 | Halt instruction |
| rsVal | input | 16 | Source register value |
| offShort | input | 16 | Sign-extended 8-bit offset |
| offLong | input | 16 | Sign-extended 11-bit displacement |
| epcVal | input | 16 | Saved exception return address |
| pcQ | output | 16 | Current program counter |
| nextPc | output | 16 | Program counter for the next cycle |
| linkVal | output | 16 | Return-link value, pcQ + 2 |
| redirect | output | 1 | Non-sequential transfer, used to flush |
| halted | output | 1 | PC frozen after a halt |

## Verification
The bench targets the edge cases of the branch test:
- A register value of 0x8000 must take the negative test and fail the non-negative test. A design that compares the whole word against zero, instead of using bit 15 alone, gets one of these two wrong.
- A value of zero must take the zero test and fail the nonzero test.

Addresses that wrap past 0xFFFE must come back to low addresses. A design that widens or saturates the adder would miss the wrap. With every flag raised at once, the bench checks the precedence order, so a design with swapped priorities would land on the wrong target. After a halt, the bench keeps feeding jumps and returns, which exposes a design that lets the PC move again or that raises a spurious flush.

// File: rtl/nextPcPkg.sv
package nextPcPkg;
  // Branch test encodings carried on branchCond.
  localparam logic [1:0] COND_ZERO    = 2'b00;
  localparam logic [1:0] COND_NONZERO = 2'b01;
  localparam logic [1:0] COND_NEG     = 2'b10;
  localparam logic [1:0] COND_NONNEG  = 2'b11;

  // Strobes from control to datapath; all zero selects the sequential address.
  typedef struct packed {
    logic useLongRel;
    logic useShortRel;
    logic useReg;
    logic useEpc;
    logic hold;
  } pcStrobeT;
endpackage

// File: rtl/nextPcCtrl.sv
module nextPcCtrl
  import nextPcPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       jumpRel,
  input  logic       jumpReg,
  input  logic       branchEn,
  input  logic [1:0] branchCond,
  input  logic       rtiEn,
  input  logic       haltEn,
  input  logic       rsZero,
  input  logic       rsNeg,
  output pcStrobeT   strobe,
  output logic       redirect,
  output logic       halted
);
  logic condMet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       halted <= 1'b0;
    else if (haltEn) halted <= 1'b1;
  end

  always_comb begin
    unique case (branchCond)
      COND_ZERO:    condMet = rsZero;
      COND_NONZERO: condMet = !rsZero;
      COND_NEG:     condMet = rsNeg;
      default:      condMet = !rsNeg;
    endcase
  end

  always_comb begin
    strobe   = '0;
    redirect = 1'b0;
    if (halted) begin
      strobe.hold = 1'b1;
    end else if (haltEn) begin
      // step past the halt sequentially
    end else if (rtiEn) begin
      strobe.useEpc = 1'b1;
      redirect      = 1'b1;
    end else if (jumpReg) begin
      strobe.useReg = 1'b1;
      redirect      = 1'b1;
    end else if (jumpRel) begin
      strobe.useLongRel = 1'b1;
      redirect          = 1'b1;
    end else if (branchEn && condMet) begin
      strobe.useShortRel = 1'b1;
      redirect           = 1'b1;
    end
  end
endmodule

// File: rtl/nextPcPath.sv
module nextPcPath
  import nextPcPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int INST_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcStrobeT          strobe,
  input  logic [ADDR_W-1:0] rsVal,
  input  logic [ADDR_W-1:0] offShort,
  input  logic [ADDR_W-1:0] offLong,
  input  logic [ADDR_W-1:0] epcVal,
  output logic [ADDR_W-1:0] pcQ,
  output logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] linkVal,
  output logic              rsZero,
  output logic              rsNeg
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_STEP);
  localparam int SIGN_BIT = ADDR_W - 1;

  logic [ADDR_W-1:0] seqPc, relOff, relTgt, regTgt;

  assign seqPc   = pcQ + STEP;
  assign relOff  = strobe.useLongRel ? offLong : offShort;
  assign relTgt  = seqPc + relOff;
  assign regTgt  = rsVal + offShort;
  assign linkVal = seqPc;
  assign rsZero  = (rsVal == '0);
  assign rsNeg   = rsVal[SIGN_BIT];

  always_comb begin
    if (strobe.hold)                                 nextPc = pcQ;
    else if (strobe.useEpc)                          nextPc = epcVal;
    else if (strobe.useReg)                          nextPc = regTgt;
    else if (strobe.useLongRel | strobe.useShortRel) nextPc = relTgt;
    else                                             nextPc = seqPc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= nextPc;
  end
endmodule

// File: rtl/nextPcUnit.sv
module nextPcUnit
  import nextPcPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int INST_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              jumpRel,
  input  logic              jumpReg,
  input  logic              branchEn,
  input  logic [1:0]        branchCond,
  input  logic              rtiEn,
  input  logic              haltEn,
  input  logic [ADDR_W-1:0] rsVal,
  input  logic [ADDR_W-1:0] offShort,
  input  logic [ADDR_W-1:0] offLong,
  input  logic [ADDR_W-1:0] epcVal,
  output logic [ADDR_W-1:0] pcQ,
  output logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] linkVal,
  output logic              redirect,
  output logic              halted
);
  pcStrobeT strobe;
  logic     rsZero, rsNeg;

  nextPcCtrl uCtrl (
    .clk(clk), .rstN(rstN), .jumpRel(jumpRel), .jumpReg(jumpReg),
    .branchEn(branchEn), .branchCond(branchCond), .rtiEn(rtiEn),
    .haltEn(haltEn), .rsZero(rsZero), .rsNeg(rsNeg),
    .strobe(strobe), .redirect(redirect), .halted(halted)
  );

  nextPcPath #(.ADDR_W(ADDR_W), .INST_STEP(INST_STEP)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rsVal(rsVal),
    .offShort(offShort), .offLong(offLong), .epcVal(epcVal),
    .pcQ(pcQ), .nextPc(nextPc), .linkVal(linkVal),
    .rsZero(rsZero), .rsNeg(rsNeg)
  );
endmodule

// File: rtl/nextPcChecker.sv
module nextPcChecker #(
  parameter int ADDR_W    = 16,
  parameter int INST_STEP = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              jumpRel,
  input logic              jumpReg,
  input logic              branchEn,
  input logic              rtiEn,
  input logic              haltEn,
  input logic [ADDR_W-1:0] epcVal,
  input logic [ADDR_W-1:0] pcQ,
  input logic [ADDR_W-1:0] nextPc,
  input logic [ADDR_W-1:0] linkVal,
  input logic              redirect,
  input logic              halted
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_STEP);

  // R2: plain sequential step
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && !jumpRel && !jumpReg && !branchEn && !rtiEn && !haltEn)
      |=> pcQ == $past(pcQ) + STEP);

  // R6, R9: exception return wins over every jump and branch
  p_rti_target_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && rtiEn && !haltEn) |=> pcQ == $past(epcVal));

  // R7: halt steps once past itself and sets the status
  p_halt_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && haltEn) |=> (halted && pcQ == $past(pcQ) + STEP));

  // R8: frozen while halted
  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(pcQ)));

  // R8: no flush request while halted
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!redirect && nextPc == pcQ));

  // R10: link value tracks the register
  p_link_value_r10: assert property (@(posedge clk) disable iff (!rstN)
    linkVal == pcQ + STEP);
endmodule

bind nextPcUnit nextPcChecker #(.ADDR_W(ADDR_W), .INST_STEP(INST_STEP)) uChk (
  .clk(clk), .rstN(rstN), .jumpRel(jumpRel), .jumpReg(jumpReg),
  .branchEn(branchEn), .rtiEn(rtiEn), .haltEn(haltEn), .epcVal(epcVal),
  .pcQ(pcQ), .nextPc(nextPc), .linkVal(linkVal), .redirect(redirect),
  .halted(halted)
);

// File: tb/sim_nextPcUnit.sv
`timescale 1ns/1ps
module sim_nextPcUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic jumpRel = 0, jumpReg = 0, branchEn = 0, rtiEn = 0, haltEn = 0;
  logic [1:0] branchCond = 2'b00;
  logic [15:0] rsVal = 0, offShort = 0, offLong = 0, epcVal = 0;
  logic [15:0] pcQ, nextPc, linkVal;
  logic redirect, halted;

  int total = 0;
  int bad = 0;
  logic [15:0] mPc;
  logic mHalted;

  always #2.5 clk = ~clk;

  nextPcUnit u0 (
    .clk(clk), .rstN(rstN), .jumpRel(jumpRel), .jumpReg(jumpReg),
    .branchEn(branchEn), .branchCond(branchCond), .rtiEn(rtiEn),
    .haltEn(haltEn), .rsVal(rsVal), .offShort(offShort), .offLong(offLong),
    .epcVal(epcVal), .pcQ(pcQ), .nextPc(nextPc), .linkVal(linkVal),
    .redirect(redirect), .halted(halted)
  );

  // Reference: returns {redirect, next PC} from the requirement text.
  function automatic logic [16:0] refStep(logic [15:0] pc, logic hlt);
    logic cond;
    case (branchCond)
      2'b00: cond = (rsVal == 16'h0);
      2'b01: cond = (rsVal != 16'h0);
      2'b10: cond = rsVal[15];
      default: cond = !rsVal[15];
    endcase
    if (hlt)                  return {1'b0, pc};
    if (haltEn)               return {1'b0, pc + 16'd2};
    if (rtiEn)                return {1'b1, epcVal};
    if (jumpReg)              return {1'b1, rsVal + offShort};
    if (jumpRel)              return {1'b1, pc + 16'd2 + offLong};
    if (branchEn && cond)     return {1'b1, pc + 16'd2 + offShort};
    return {1'b0, pc + 16'd2};
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clearFlags();
    jumpRel = 0; jumpReg = 0; branchEn = 0; rtiEn = 0; haltEn = 0;
  endtask

  // Called just after a negedge with inputs driven; checks then advances one cycle.
  task automatic stepCheck(string tag);
    logic [16:0] e;
    #1;
    e = refStep(mPc, mHalted);
    chk(tag, "pcQ", pcQ, mPc);
    chk(tag, "nextPc", nextPc, e[15:0]);
    chk(tag, "redirect", {15'b0, redirect}, {15'b0, e[16]});
    chk("R10", "linkVal", linkVal, mPc + 16'd2);
    chk(tag, "halted", {15'b0, halted}, {15'b0, mHalted});
    @(posedge clk);
    mPc = e[15:0];
    if (haltEn) mHalted = 1'b1;
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    clearFlags();
    @(negedge clk);
    #1;
    chk("R1", "pcQ in reset", pcQ, 16'h0);
    chk("R1", "halted in reset", {15'b0, halted}, 16'h0);
    @(negedge clk);
    rstN = 1'b1;
    mPc = 16'h0;
    mHalted = 1'b0;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    int haltAge;
    string tag;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    doReset();

    // R1: first cycle after reset is sequential from 0
    stepCheck("R1");
    stepCheck("R2");

    // R3: relative jump backwards to wrap region
    jumpRel = 1; offLong = 16'hFFF8; stepCheck("R3"); clearFlags();
    // R4: register jump to near top, then sequential wrap
    jumpReg = 1; rsVal = 16'hFFF0; offShort = 16'h000E; stepCheck("R4"); clearFlags();
    stepCheck("R2");   // 0xFFFE + 2 wraps to 0
    // R5: boundary values of the branch test
    branchEn = 1; offShort = 16'h0010;
    rsVal = 16'h8000; branchCond = 2'b10; stepCheck("R5");
    rsVal = 16'h8000; branchCond = 2'b11; stepCheck("R5");
    rsVal = 16'h0000; branchCond = 2'b00; stepCheck("R5");
    rsVal = 16'h0000; branchCond = 2'b01; stepCheck("R5");
    rsVal = 16'h7FFF; branchCond = 2'b11; stepCheck("R5");
    rsVal = 16'h0001; branchCond = 2'b00; stepCheck("R5");
    clearFlags();
    // R6: exception return
    rtiEn = 1; epcVal = 16'h1234; stepCheck("R6"); clearFlags();
    // R9: all flags at once without halt -> exception return wins
    rtiEn = 1; jumpReg = 1; jumpRel = 1; branchEn = 1; branchCond = 2'b01;
    rsVal = 16'h0100; epcVal = 16'h2222; stepCheck("R9");
    rtiEn = 0; stepCheck("R9");    // register jump beats relative and branch
    jumpReg = 0; stepCheck("R9");  // relative jump beats branch
    clearFlags();
    // R7, R9: halt beats everything
    haltEn = 1; rtiEn = 1; jumpReg = 1; stepCheck("R7"); clearFlags();
    // R8: flags ignored while halted
    rtiEn = 1; epcVal = 16'h4444; stepCheck("R8"); clearFlags();
    jumpRel = 1; offLong = 16'h0200; stepCheck("R8"); clearFlags();
    haltEn = 1; stepCheck("R8"); clearFlags();
    doReset();

    // Constrained random mix
    haltAge = 0;
    for (int i = 0; i < 4000; i++) begin
      jumpRel    = ($urandom_range(0, 9) == 0);
      jumpReg    = ($urandom_range(0, 9) == 0);
      branchEn   = ($urandom_range(0, 2) == 0);
      rtiEn      = ($urandom_range(0, 14) == 0);
      haltEn     = ($urandom_range(0, 59) == 0);
      branchCond = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 3))
        0: rsVal = 16'h0000;
        1: rsVal = 16'h8000;
        default: rsVal = 16'($urandom);
      endcase
      offShort = {{8{1'($urandom_range(0, 1))}}, 8'($urandom)};
      offLong  = {{5{1'($urandom_range(0, 1))}}, 11'($urandom)};
      epcVal   = 16'($urandom) & 16'hFFFE;
      if (mHalted)      tag = "R8";
      else if (haltEn)  tag = "R7";
      else if (rtiEn)   tag = "R6";
      else if (jumpReg) tag = "R4";
      else if (jumpRel) tag = "R3";
      else if (branchEn) tag = "R5";
      else tag = "R2";
      stepCheck(tag);
      if (mHalted) haltAge++;
      if (haltAge > 3) begin
        haltAge = 0;
        doReset();
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule